// File: doc/BRIEF.md
# Abstract Command Engine for an Execution-Based Debug Module

This block is the command side of a debug module that runs register accesses by borrowing a parked hart. A debugger reaches it through a word-addressed register port: an address, write data, a write strobe and combinational read data. Through that port it can request a halt or a resume, load a shared data word and a small program buffer, and issue an access-register command. The block accepts only 32-bit general-register transfers. A valid command does not touch the register file itself. It raises an execute request toward the hart, which is spinning in its park loop.

The hart uses a second, narrow memory-mapped window. Through it the hart reads the request flags, acknowledges each request, and reads or writes the shared data word. It can also fetch the code the command needs: a generated load or store that moves the data word to or from the selected register, then the program buffer entries, then a closing `ebreak`. If the program buffer is not to run after the transfer, each buffer slot reads back as `ebreak`.

A three-state sequencer tracks each command. EX_IDLE moves to EX_ISSUE on *launch*, which is an accepted command write. EX_ISSUE moves to EX_WAIT on *post*, one cycle later, when the execute flag is raised. EX_WAIT returns to EX_IDLE on *retire*, which is the hart acknowledging either completion or an exception. The command is busy whenever the sequencer is not in EX_IDLE.

Top module: `dmx_abstract_engine`

## Requirements
- R1: After reset the shared data word reads 0, every program buffer entry reads 0x00000013, the control/status word (debug address 0x16) reads 0x02000001, and no halt, resume or execute request is raised.
- R2: The module status word (debug address 0x11) always has bit 7 (authenticated) set and bits 3:0 equal to 2. The hart-info word (debug address 0x12) reads scratch count 1 in bits 23:20, 0 in bit 16, data size 1 in bits 15:12, and the low 12 bits of the data-window base in bits 11:0 (0x00101F80 by default).
- R3: A write to the run-control word (debug address 0x10) with bit 31 set, while the hart is not halted, raises the halt request on the next edge. The request stays up until the hart writes its flag word (window index 1) with bit 0 set. After that the status word shows bits 9:8 set and bits 11:10 clear.
- R4: A command (debug address 0x17) is refused with error code 2, and no execution starts, if any of these holds: bits 31:24 are non-zero, bit 23 is set, bits 22:20 differ from 010, bit 19 is set, or bit 17 is set with bits 15:0 outside 0x1000–0x101F.
- R5: A well-formed command issued while the hart is not halted is refused with error code 4.
- R6: For an accepted command, busy (bit 12 of the control/status word) is set after the write edge. The execute request (hart flag bit 2) follows one edge later. Busy and the request both clear on the edge at which the hart writes its flag word with bit 2 (done) or bit 3 (exception).
- R7: Window index 2 holds the transfer instruction. With bit 17 clear it is 0x00000013. With bits 17 and 16 set it is `lw x[regno], base(x0)`. With bit 17 set and bit 16 clear it is `sw x[regno], base(x0)`. Here base is the signed low 12 bits of the data-window base.
- R8: Window indices 3 and 4 return the program buffer entries when command bit 18 was set. Otherwise they return 0x00100073. Index 5 always returns 0x00100073.
- R9: A debugger write to the data word, a program buffer entry or the command register while busy leaves its target unchanged and sets error code 1 if no error is recorded.
- R10: Writing the control/status word clears each error bit written as 1 and leaves the others. While the error code is non-zero, command writes are ignored.
- R11: An exception acknowledge (flag-word bit 3) during execution retires the command and records error code 3.
- R12: The hart's writes to window index 0 and the debugger's writes to debug address 0x04 update one shared word that both sides read. If both write in the same cycle, the hart's value is kept.
- R13: Run-control bit 30, written while halted, raises the resume request and clears resume-acknowledge. A hart acknowledge with flag bit 1 clears the request and the halted state and sets status bits 17:16. Bit 30 written while running has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_addr | input | 7 | Debugger register address |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_we | input | 1 | Debugger write strobe |
| dbg_rdata | output | 32 | Debugger read data for `dbg_addr` |
| cpu_addr | input | 3 | Hart window word index |
| cpu_wdata | input | 32 | Hart write data |
| cpu_we | input | 1 | Hart write strobe |
| cpu_rdata | output | 32 | Hart read data for `cpu_addr` |
| halt_req | output | 1 | Halt request flag toward the hart |
| resume_req | output | 1 | Resume request flag toward the hart |
| exec_req | output | 1 | Execute request flag toward the hart |

## Verification
The assertions check a set of rules on every cycle. The execute request never appears without busy. Busy only falls right after a hart done or exception acknowledge. A pending halt request holds until it is acknowledged. Resume is only requested while the hart is halted. A command is only accepted when no error was recorded. A busy-time write cannot move the data word. A wrong command type never starts execution. Other behaviour can only be shown by the bench's scenarios, against its cycle model: the exact error code picked for each malformed field, the encoding of the generated load and store, the gating of the program buffer by the post-execute bit, the partial clearing of error bits, and the hart's write winning a collision on the data word.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned DBG_AW = 7;
    localparam int unsigned CPU_AW = 3;

    // debugger-side register addresses (fixed by the debugger's decoder)
    localparam logic [DBG_AW-1:0] DA_DATA0  = 7'h04;
    localparam logic [DBG_AW-1:0] DA_RUNCTL = 7'h10;
    localparam logic [DBG_AW-1:0] DA_STATUS = 7'h11;
    localparam logic [DBG_AW-1:0] DA_HINFO  = 7'h12;
    localparam logic [DBG_AW-1:0] DA_ACS    = 7'h16;
    localparam logic [DBG_AW-1:0] DA_CMD    = 7'h17;
    localparam logic [DBG_AW-1:0] DA_PB0    = 7'h20;

    // hart-side window word indices
    localparam logic [CPU_AW-1:0] CW_DATA  = 3'd0;
    localparam logic [CPU_AW-1:0] CW_FLAGS = 3'd1;
    localparam logic [CPU_AW-1:0] CW_XFER  = 3'd2;
    localparam logic [CPU_AW-1:0] CW_PB0   = 3'd3;

    localparam logic [WORD_W-1:0] INSN_NOP    = 32'h0000_0013;
    localparam logic [WORD_W-1:0] INSN_EBREAK = 32'h0010_0073;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BUSY    = 3'd1,
        ERR_UNSUP   = 3'd2,
        ERR_EXCEPT  = 3'd3,
        ERR_HALTRES = 3'd4
    } cmderr_e;

    typedef enum logic [1:0] {
        EX_IDLE  = 2'd0,
        EX_ISSUE = 2'd1,
        EX_WAIT  = 2'd2
    } exec_state_e;

    typedef struct packed {
        logic       postexec;
        logic       transfer;
        logic       to_gpr;
        logic [4:0] gpr;
    } cmd_fields_t;

    function automatic logic [WORD_W-1:0] enc_load(input logic [4:0] rd, input logic [11:0] ofs);
        return {ofs, 5'd0, 3'b010, rd, 7'b0000011};
    endfunction

    function automatic logic [WORD_W-1:0] enc_store(input logic [4:0] rs2, input logic [11:0] ofs);
        return {ofs[11:5], rs2, 5'd0, 3'b010, ofs[4:0], 7'b0100011};
    endfunction

endpackage

// File: rtl/dmx_cmd_check.sv
module dmx_cmd_check
    import dmx_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              halted_i,
    output cmderr_e           verdict_o
);

    logic unsupported;
    logic regno_bad;
    logic unused_fields;

    assign unused_fields = ^{cmd_i[18], cmd_i[16]};

    assign regno_bad   = (cmd_i[15:0] < 16'h1000) || (cmd_i[15:0] > 16'h101F);
    assign unsupported = (cmd_i[31:24] != 8'd0) || cmd_i[23] ||
                         (cmd_i[22:20] != 3'b010) || cmd_i[19] ||
                         (cmd_i[17] && regno_bad);

    always_comb begin
        verdict_o = ERR_NONE;
        if (unsupported) begin
            verdict_o = ERR_UNSUP;
        end else if (!halted_i) begin
            verdict_o = ERR_HALTRES;
        end
    end

endmodule

// File: rtl/dmx_hart_link.sv
module dmx_hart_link (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_set_i,
    input  logic resume_set_i,
    input  logic ack_halted_i,
    input  logic ack_resumed_i,
    output logic halt_req_o,
    output logic resume_req_o,
    output logic halted_o,
    output logic resumeack_o
);

    logic halt_q, resume_q, halted_q, rack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q   <= 1'b0;
            resume_q <= 1'b0;
            halted_q <= 1'b0;
            rack_q   <= 1'b0;
        end else begin
            if (halt_set_i && !halted_q) begin
                halt_q <= 1'b1;
            end
            if (resume_set_i && halted_q) begin
                resume_q <= 1'b1;
                rack_q   <= 1'b0;
            end
            if (ack_halted_i) begin
                halt_q   <= 1'b0;
                halted_q <= 1'b1;
            end
            if (ack_resumed_i) begin
                resume_q <= 1'b0;
                halted_q <= 1'b0;
                rack_q   <= 1'b1;
            end
        end
    end

    assign halt_req_o   = halt_q;
    assign resume_req_o = resume_q;
    assign halted_o     = halted_q;
    assign resumeack_o  = rack_q;

endmodule

// File: rtl/dmx_exec_fsm.sv
module dmx_exec_fsm
    import dmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    input  logic fault_i,
    output logic busy_o,
    output logic exec_req_o,
    output logic fault_taken_o
);

    exec_state_e state_q, state_d;
    logic        exec_q;
    logic        retire;

    assign retire = (state_q == EX_WAIT) && (done_i || fault_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EX_IDLE:  if (start_i) state_d = EX_ISSUE;
            EX_ISSUE: state_d = EX_WAIT;
            EX_WAIT:  if (done_i || fault_i) state_d = EX_IDLE;
            default:  state_d = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= 1'b0;
        end else begin
            unique case (state_q)
                EX_ISSUE: exec_q <= 1'b1;
                EX_WAIT:  if (retire) exec_q <= 1'b0;
                default:  exec_q <= exec_q;
            endcase
        end
    end

    assign busy_o        = (state_q != EX_IDLE);
    assign exec_req_o    = exec_q;
    assign fault_taken_o = (state_q == EX_WAIT) && fault_i;

endmodule

// File: rtl/dmx_code_gen.sv
module dmx_code_gen
    import dmx_pkg::*;
#(
    parameter logic [31:0] DATA_BASE = 32'hFFFF_FF80,
    parameter int unsigned PB_DEPTH  = 2
) (
    input  cmd_fields_t                      cmd_i,
    input  logic [PB_DEPTH-1:0][WORD_W-1:0]  pb_i,
    input  logic [CPU_AW-1:0]                addr_i,
    output logic [WORD_W-1:0]                word_o
);

    localparam logic [11:0]       OFS      = DATA_BASE[11:0];
    localparam logic [CPU_AW-1:0] CW_TAIL  = CW_PB0 + CPU_AW'(PB_DEPTH);

    logic [WORD_W-1:0] xfer_word;

    always_comb begin
        if (!cmd_i.transfer) begin
            xfer_word = INSN_NOP;
        end else if (cmd_i.to_gpr) begin
            xfer_word = enc_load(cmd_i.gpr, OFS);
        end else begin
            xfer_word = enc_store(cmd_i.gpr, OFS);
        end
    end

    always_comb begin
        word_o = '0;
        if (addr_i == CW_XFER) begin
            word_o = xfer_word;
        end
        for (int i = 0; i < int'(PB_DEPTH); i++) begin
            if (addr_i == CW_PB0 + CPU_AW'(i)) begin
                word_o = cmd_i.postexec ? pb_i[i] : INSN_EBREAK;
            end
        end
        if (addr_i == CW_TAIL) begin
            word_o = INSN_EBREAK;
        end
    end

endmodule

// File: rtl/dmx_abstract_engine.sv
module dmx_abstract_engine
    import dmx_pkg::*;
#(
    parameter logic [31:0] DATA_BASE = 32'hFFFF_FF80,
    parameter int unsigned PB_DEPTH  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  dbg_addr,
    input  logic [31:0] dbg_wdata,
    input  logic        dbg_we,
    output logic [31:0] dbg_rdata,
    input  logic [2:0]  cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic        cpu_we,
    output logic [31:0] cpu_rdata,
    output logic        halt_req,
    output logic        resume_req,
    output logic        exec_req
);

    localparam logic [11:0] DATA_OFS = DATA_BASE[11:0];
    localparam logic [4:0]  PB_SIZE  = 5'(PB_DEPTH);

    logic                            busy;
    logic                            fault_taken;
    logic                            halted;
    logic                            resumeack;
    cmderr_e                         cmderr_q;
    cmderr_e                         verdict;
    logic [WORD_W-1:0]               data0_q;
    logic [PB_DEPTH-1:0][WORD_W-1:0] pb_q;
    cmd_fields_t                     cmd_q;
    logic [WORD_W-1:0]               gen_word;

    logic [PB_DEPTH-1:0] pb_sel;
    logic wr_data0, wr_cmd, wr_acs, wr_runctl, wr_pb;
    logic busy_touch, start;
    logic flags_wr, ack_halted, ack_resumed, ack_done, ack_fault;

    // ---------------- debugger-side decode ----------------
    assign wr_data0  = dbg_we && (dbg_addr == DA_DATA0);
    assign wr_cmd    = dbg_we && (dbg_addr == DA_CMD);
    assign wr_acs    = dbg_we && (dbg_addr == DA_ACS);
    assign wr_runctl = dbg_we && (dbg_addr == DA_RUNCTL);
    assign wr_pb     = dbg_we && (|pb_sel);

    assign busy_touch = busy && (wr_data0 || wr_cmd || wr_pb);
    assign start      = wr_cmd && !busy && (cmderr_q == ERR_NONE) && (verdict == ERR_NONE);

    // ---------------- hart-side decode ----------------
    assign flags_wr    = cpu_we && (cpu_addr == CW_FLAGS);
    assign ack_halted  = flags_wr && cpu_wdata[0];
    assign ack_resumed = flags_wr && cpu_wdata[1];
    assign ack_done    = flags_wr && cpu_wdata[2];
    assign ack_fault   = flags_wr && cpu_wdata[3];

    // ---------------- program buffer ----------------
    for (genvar g = 0; g < int'(PB_DEPTH); g++) begin : g_pb
        assign pb_sel[g] = (dbg_addr == DA_PB0 + 7'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pb_q[g] <= INSN_NOP;
            end else if (dbg_we && pb_sel[g] && !busy) begin
                pb_q[g] <= dbg_wdata;
            end
        end
    end

    // ---------------- shared data word ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data0_q <= '0;
        end else begin
            if (wr_data0 && !busy) begin
                data0_q <= dbg_wdata;
            end
            if (cpu_we && (cpu_addr == CW_DATA)) begin
                data0_q <= cpu_wdata;
            end
        end
    end

    // ---------------- latched command fields ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q.postexec <= dbg_wdata[18];
            cmd_q.transfer <= dbg_wdata[17];
            cmd_q.to_gpr   <= dbg_wdata[16];
            cmd_q.gpr      <= dbg_wdata[4:0];
        end
    end

    // ---------------- error code ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmderr_q <= ERR_NONE;
        end else begin
            if (busy_touch) begin
                if (cmderr_q == ERR_NONE) cmderr_q <= ERR_BUSY;
            end else if (wr_cmd && (cmderr_q == ERR_NONE) && (verdict != ERR_NONE)) begin
                cmderr_q <= verdict;
            end else if (wr_acs) begin
                cmderr_q <= cmderr_e'(cmderr_q & ~dbg_wdata[10:8]);
            end
            if (fault_taken && (cmderr_q == ERR_NONE)) begin
                cmderr_q <= ERR_EXCEPT;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    dmx_cmd_check u_check (
        .cmd_i     (dbg_wdata),
        .halted_i  (halted),
        .verdict_o (verdict)
    );

    dmx_hart_link u_link (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_set_i    (wr_runctl && dbg_wdata[31]),
        .resume_set_i  (wr_runctl && dbg_wdata[30]),
        .ack_halted_i  (ack_halted),
        .ack_resumed_i (ack_resumed),
        .halt_req_o    (halt_req),
        .resume_req_o  (resume_req),
        .halted_o      (halted),
        .resumeack_o   (resumeack)
    );

    dmx_exec_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .done_i        (ack_done),
        .fault_i       (ack_fault),
        .busy_o        (busy),
        .exec_req_o    (exec_req),
        .fault_taken_o (fault_taken)
    );

    dmx_code_gen #(
        .DATA_BASE (DATA_BASE),
        .PB_DEPTH  (PB_DEPTH)
    ) u_gen (
        .cmd_i  (cmd_q),
        .pb_i   (pb_q),
        .addr_i (cpu_addr),
        .word_o (gen_word)
    );

    // ---------------- read muxes ----------------
    always_comb begin
        dbg_rdata = '0;
        unique case (dbg_addr)
            DA_DATA0:  dbg_rdata = data0_q;
            DA_RUNCTL: dbg_rdata = 32'h0000_0001;
            DA_STATUS: dbg_rdata = {14'd0, resumeack, resumeack, 4'd0,
                                    !halted, !halted, halted, halted,
                                    1'b1, 3'd0, 4'd2};
            DA_HINFO:  dbg_rdata = {8'd0, 4'd1, 3'd0, 1'b0, 4'd1, DATA_OFS};
            DA_ACS:    dbg_rdata = {3'd0, PB_SIZE, 11'd0, busy, 1'b0,
                                    cmderr_q, 4'd0, 4'd1};
            default:   dbg_rdata = '0;
        endcase
        for (int i = 0; i < int'(PB_DEPTH); i++) begin
            if (pb_sel[i]) dbg_rdata = pb_q[i];
        end
    end

    always_comb begin
        if (cpu_addr == CW_DATA) begin
            cpu_rdata = data0_q;
        end else if (cpu_addr == CW_FLAGS) begin
            cpu_rdata = {29'd0, exec_req, resume_req, halt_req};
        end else begin
            cpu_rdata = gen_word;
        end
    end

endmodule

// File: rtl/dmx_engine_chk.sv
module dmx_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        exec_req,
    input logic        halt_req,
    input logic        resume_req,
    input logic        halted,
    input logic [2:0]  cmderr,
    input logic [31:0] data0,
    input logic [6:0]  dbg_addr,
    input logic        dbg_we,
    input logic [31:0] dbg_wdata,
    input logic [2:0]  cpu_addr,
    input logic        cpu_we,
    input logic [31:0] cpu_wdata
);

    // R6
    exec_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> busy);

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cpu_we && (cpu_addr == 3'd1) && (cpu_wdata[2] || cpu_wdata[3])));

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !(cpu_we && (cpu_addr == 3'd1) && cpu_wdata[0])) |=> halt_req);

    // R13
    resume_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> halted);

    // R10
    accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmderr) == 3'd0));

    // R9
    busy_data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dbg_we && (dbg_addr == 7'h04) && !(cpu_we && (cpu_addr == 3'd0))) |=> $stable(data0));

    // R4
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dbg_we && (dbg_addr == 7'h17) && (dbg_wdata[31:24] != 8'd0)) |=> !busy);

endmodule

bind dmx_abstract_engine dmx_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .exec_req   (exec_req),
    .halt_req   (halt_req),
    .resume_req (resume_req),
    .halted     (halted),
    .cmderr     (cmderr_q),
    .data0      (data0_q),
    .dbg_addr   (dbg_addr),
    .dbg_we     (dbg_we),
    .dbg_wdata  (dbg_wdata),
    .cpu_addr   (cpu_addr),
    .cpu_we     (cpu_we),
    .cpu_wdata  (cpu_wdata)
);

// File: tb/sim_dmx_abstract_engine.sv
`timescale 1ns/1ps
module sim_dmx_abstract_engine;

    localparam logic [31:0] BASE = 32'hFFFF_FF80;
    localparam logic [31:0] NOP  = 32'h0000_0013;
    localparam logic [31:0] EBRK = 32'h0010_0073;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_rdata;
    logic [2:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_rdata;
    logic        halt_req, resume_req, exec_req;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    dmx_abstract_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_we(dbg_we), .dbg_rdata(dbg_rdata),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .halt_req(halt_req), .resume_req(resume_req), .exec_req(exec_req)
    );

    // behavioural reference state
    logic [31:0] md0, mpb0, mpb1, mcmd;
    int          merr, mphase;
    bit          mhalt, mres, mexec, mhalted, mrack;

    task automatic model_reset();
        md0 = 0; mpb0 = NOP; mpb1 = NOP; mcmd = 0;
        merr = 0; mphase = 0;
        mhalt = 0; mres = 0; mexec = 0; mhalted = 0; mrack = 0;
    endtask

    function automatic bit cmd_bad(input logic [31:0] c);
        return (c[31:24] != 0) || c[23] || (c[22:20] != 3'd2) || c[19] ||
               (c[17] && ((c[15:0] < 16'h1000) || (c[15:0] > 16'h101F)));
    endfunction

    task automatic model_tick();
        bit busy_now = (mphase != 0);
        logic [31:0] n_d0 = md0, n_pb0 = mpb0, n_pb1 = mpb1, n_cmd = mcmd;
        int n_err = merr, n_phase = mphase;
        bit n_halt = mhalt, n_res = mres, n_exec = mexec, n_halted = mhalted, n_rack = mrack;
        bit touch = 0;
        if (dbg_we) begin
            case (dbg_addr)
                7'h04: if (busy_now) touch = 1; else n_d0 = dbg_wdata;
                7'h20: if (busy_now) touch = 1; else n_pb0 = dbg_wdata;
                7'h21: if (busy_now) touch = 1; else n_pb1 = dbg_wdata;
                7'h17: if (busy_now) touch = 1;
                       else if (merr == 0) begin
                           if (cmd_bad(dbg_wdata)) n_err = 2;
                           else if (!mhalted) n_err = 4;
                           else begin n_cmd = dbg_wdata; n_phase = 1; end
                       end
                7'h16: n_err = merr & ~int'(dbg_wdata[10:8]);
                7'h10: begin
                    if (dbg_wdata[31] && !mhalted) n_halt = 1;
                    if (dbg_wdata[30] && mhalted) begin n_res = 1; n_rack = 0; end
                end
                default: ;
            endcase
            if (touch && merr == 0) n_err = 1;
        end
        if (mphase == 1) begin n_phase = 2; n_exec = 1; end
        if (cpu_we) begin
            if (cpu_addr == 0) n_d0 = cpu_wdata;
            if (cpu_addr == 1) begin
                if (cpu_wdata[0]) begin n_halt = 0; n_halted = 1; end
                if (cpu_wdata[1]) begin n_res = 0; n_halted = 0; n_rack = 1; end
                if (mphase == 2 && (cpu_wdata[2] || cpu_wdata[3])) begin
                    n_exec = 0; n_phase = 0;
                    if (cpu_wdata[3] && merr == 0) n_err = 3;
                end
            end
        end
        md0 = n_d0; mpb0 = n_pb0; mpb1 = n_pb1; mcmd = n_cmd; merr = n_err; mphase = n_phase;
        mhalt = n_halt; mres = n_res; mexec = n_exec; mhalted = n_halted; mrack = n_rack;
    endtask

    function automatic logic [31:0] exp_dbg(input logic [6:0] a);
        case (a)
            7'h04: return md0;
            7'h10: return 32'h1;
            7'h11: return (mrack ? 32'h0003_0000 : 0) | (mhalted ? 32'h300 : 32'hC00) | 32'h82;
            7'h12: return (32'd1 << 20) | (32'd1 << 12) | (BASE & 32'hFFF);
            7'h16: return (32'd2 << 24) | ((mphase != 0) ? 32'h1000 : 0) | (32'(merr) << 8) | 32'd1;
            7'h20: return mpb0;
            7'h21: return mpb1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_cpu(input logic [2:0] a);
        logic [31:0] r = mcmd[4:0];
        logic [31:0] ofs = BASE & 32'hFFF;
        case (a)
            3'd0: return md0;
            3'd1: return {29'd0, mexec, mres, mhalt};
            3'd2: begin
                if (!mcmd[17]) return NOP;
                if (mcmd[16]) return (ofs << 20) | (32'd2 << 12) | (r << 7) | 32'h03;
                return ((ofs >> 5) << 25) | (r << 20) | (32'd2 << 12) | ((ofs & 32'h1F) << 7) | 32'h23;
            end
            3'd3: return mcmd[18] ? mpb0 : EBRK;
            3'd4: return mcmd[18] ? mpb1 : EBRK;
            3'd5: return EBRK;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %08h expected %08h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "dbg_rdata", dbg_rdata, exp_dbg(dbg_addr));
        check(tag, "cpu_rdata", cpu_rdata, exp_cpu(cpu_addr));
        check(tag, "halt_req", {31'd0, halt_req}, {31'd0, mhalt});
        check(tag, "resume_req", {31'd0, resume_req}, {31'd0, mres});
        check(tag, "exec_req", {31'd0, exec_req}, {31'd0, mexec});
    endtask

    task automatic step(input logic [6:0] da, input logic [31:0] dwd, input logic dwe,
                        input logic [2:0] ca, input logic [31:0] cwd, input logic cwe,
                        input string tag);
        dbg_addr = da; dbg_wdata = dwd; dbg_we = dwe;
        cpu_addr = ca; cpu_wdata = cwd; cpu_we = cwe;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic dw(input logic [6:0] a, input logic [31:0] d, input string tag);
        step(a, d, 1'b1, 3'd1, 0, 1'b0, tag);
    endtask
    task automatic dr(input logic [6:0] a, input string tag);
        step(a, 0, 1'b0, 3'd1, 0, 1'b0, tag);
    endtask
    task automatic cw(input logic [2:0] a, input logic [31:0] d, input string tag);
        step(7'h16, 0, 1'b0, a, d, 1'b1, tag);
    endtask
    task automatic cr(input logic [2:0] a, input string tag);
        step(7'h16, 0, 1'b0, a, 0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        compare_all("R1");
        dr(7'h16, "R1"); dr(7'h20, "R1"); dr(7'h21, "R1"); dr(7'h04, "R1");
        // R2 constant information
        dr(7'h11, "R2"); dr(7'h12, "R2");
        // R5 command while running
        dw(7'h17, 32'h0023_1005, "R5"); dr(7'h16, "R5");
        // R10 partial then full W1C
        dw(7'h16, 32'h0000_0100, "R10"); dr(7'h16, "R10");
        dw(7'h16, 32'h0000_0400, "R10"); dr(7'h16, "R10");
        // R13 resume while running ignored
        dw(7'h10, 32'h4000_0000, "R13"); dr(7'h11, "R13");
        // R3 halt handshake
        dw(7'h10, 32'h8000_0000, "R3");
        cr(3'd1, "R3"); cr(3'd1, "R3"); dr(7'h11, "R3");
        cw(3'd1, 32'h1, "R3"); dr(7'h11, "R3");
        // R12 data word both ways, collision
        dw(7'h20, 32'h0041_0113, "R8"); dw(7'h21, 32'h0000_100F, "R8");
        dw(7'h04, 32'hCAFE_F00D, "R12"); cr(3'd0, "R12");
        step(7'h04, 32'h1111_1111, 1'b1, 3'd0, 32'h2222_2222, 1'b1, "R12");
        dr(7'h04, "R12");
        dw(7'h04, 32'hCAFE_F00D, "R12");
        // R4 malformed commands
        dw(7'h17, 32'h0123_1005, "R4"); dr(7'h16, "R4");
        // R10 locked while error set
        dw(7'h17, 32'h0023_1005, "R10"); dr(7'h16, "R10");
        dw(7'h16, 32'h0000_0700, "R10");
        dw(7'h17, 32'h0033_1005, "R4"); dw(7'h16, 32'h700, "R4");
        dw(7'h17, 32'h002A_1005, "R4"); dw(7'h16, 32'h700, "R4");
        dw(7'h17, 32'h0082_1005, "R4"); dw(7'h16, 32'h700, "R4");
        dw(7'h17, 32'h0022_1020, "R4"); dw(7'h16, 32'h700, "R4");
        dw(7'h17, 32'h0022_0FFF, "R4"); dr(7'h16, "R4"); dw(7'h16, 32'h700, "R4");
        // R6 write x5 from data word, with program buffer
        dw(7'h17, 32'h0027_1005, "R6");
        dr(7'h16, "R6"); cr(3'd1, "R6");
        cr(3'd2, "R7"); cr(3'd3, "R8"); cr(3'd4, "R8"); cr(3'd5, "R8");
        // R9 writes while busy
        dw(7'h04, 32'hDEAD_BEEF, "R9"); dr(7'h04, "R9"); dr(7'h16, "R9");
        dw(7'h20, 32'h0000_0000, "R9"); dr(7'h20, "R9");
        cw(3'd1, 32'h4, "R6"); dr(7'h16, "R6");
        dw(7'h16, 32'h700, "R10");
        // R7 read x10 into data word, no program buffer
        dw(7'h17, 32'h0022_100A, "R7");
        cr(3'd2, "R7"); cr(3'd3, "R8"); cr(3'd5, "R8");
        cw(3'd0, 32'h1234_5678, "R12");
        cw(3'd1, 32'h4, "R6"); dr(7'h04, "R12");
        // R11 exception, no-transfer command
        dw(7'h17, 32'h0024_0000, "R11");
        cr(3'd2, "R7"); cr(3'd3, "R8");
        cw(3'd1, 32'h8, "R11"); dr(7'h16, "R11");
        dw(7'h16, 32'h700, "R10");
        // R13 resume handshake
        dw(7'h10, 32'h4000_0000, "R13"); cr(3'd1, "R13");
        cw(3'd1, 32'h2, "R13"); dr(7'h11, "R13");
        // R5 again after resume
        dw(7'h17, 32'h0022_1001, "R5"); dr(7'h16, "R5");
        repeat (2) dr(7'h11, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule